// File: doc/BRIEF.md
# Debug Trap Router

This block sits beside the decode stage of a small processor core. It decides how each debug trap is delivered. Three sources feed it:

- a complete one-byte breakpoint instruction leaving the decoder;
- a single-step trap raised because the trap flag was set;
- a hit reported by the debug-address comparators.

Each accepted event goes one of two ways:

- With redirection off, the block raises exception vector 1. It also tells the flags-push logic whether the saved trap flag is marked as set or left untouched.
- With redirection on, the event is sent to an attached in-circuit emulator. On a part strapped as emulator-capable, the block pulses a break strobe and holds a halted state. On a production part there is nothing to break into, so the block hangs until reset.

The redirection bit can be written directly through a debug-control write port. It is also set as a side effect whenever an emulator arms a hardware breakpoint. The production/emulator strap is sampled only while reset is asserted. Instruction fetch, the stack push and the address comparators are outside the block; they appear here only as strobes.

Top module: `dbg_trap_router`

## Requirements
- R1: While and after reset, every output is 0 and redirection is off.
- R2: Breakpoint opcode with redirection off: a breakpoint is `insn_valid_i`=1, `insn_single_i`=1 and `insn_byte_i`=0xF1. One cycle after such an edge, `exc_valid_o`=1, `exc_vector_o`=1, `tf_keep_o`=1 and `tf_set_o`=0. Any other byte, a multi-byte instruction, or `insn_valid_i`=0 raises nothing.
- R3: Single-step with redirection off: `step_trap_i` raises vector 1 with `tf_set_o`=1 and `tf_keep_o`=0.
- R4: Debug-register hit with redirection off: `drhit_i` raises vector 1 with `tf_keep_o`=1 and `tf_set_o`=0.
- R5: When several sources fire in the same cycle, the debug-register hit wins over the breakpoint opcode, and the opcode wins over the single-step. Exactly one request results.
- R6: Request outstanding:
  - `exc_valid_o` lasts one cycle.
  - `exc_vector_o`, `tf_set_o` and `tf_keep_o` hold their values until `exc_ack_i`.
  - Events that arrive while a request is outstanding are dropped.
- R7: Redirection control:
  - `redir_wr_i` loads the bit from `redir_wdata_i`.
  - `emu_arm_i` sets the bit; a write in the same cycle takes precedence.
  - An event in the same cycle as the write uses the old value.
- R8: Redirection on, emulator-capable part: any event gives a one-cycle `emu_break_o` pulse and raises `emu_halt_o`, with no exception request. `emu_halt_o` stays high until reset, and later events are ignored.
- R9: Redirection on, production part: any event raises `hang_o` with no exception request and no break strobe. `hang_o` stays high until reset, and later events are ignored.
- R10: `mode_emu_i` (1 = emulator-capable) is sampled only while reset is asserted. Changing it afterwards has no effect.
- R11: The cycle after `exc_ack_i` is applied to an outstanding request, the vector and both flag controls return to 0. A new event is then accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_emu_i | input | 1 | Part strap, sampled in reset: 1 emulator-capable, 0 production |
| insn_valid_i | input | 1 | Decoded instruction present |
| insn_single_i | input | 1 | Decoded instruction is exactly one byte long |
| insn_byte_i | input | 8 | Opcode byte of the decoded instruction |
| step_trap_i | input | 1 | Single-step trap from the trap flag |
| drhit_i | input | 1 | Debug-register address match |
| redir_wr_i | input | 1 | Direct write of the redirection bit |
| redir_wdata_i | input | 1 | Value for the direct write |
| emu_arm_i | input | 1 | Emulator armed a hardware breakpoint; sets redirection |
| exc_ack_i | input | 1 | Exception request taken |
| exc_valid_o | output | 1 | One-cycle exception request |
| exc_vector_o | output | 8 | Exception vector, held until acknowledge |
| tf_set_o | output | 1 | Mark the trap flag as set in the saved flags image |
| tf_keep_o | output | 1 | Leave the saved trap flag unaltered |
| emu_break_o | output | 1 | One-cycle break strobe to the emulator |
| emu_halt_o | output | 1 | Emulation halted |
| hang_o | output | 1 | Production part locked up |

## Verification
The properties assume that `exc_ack_i` is driven only while a request is outstanding, or is harmless otherwise. They also assume the strap input matters only inside reset, so each end state is tied to the strap that was latched rather than to the live pin.

The stimulus changes inputs only on falling edges. It raises acknowledge only after a request has been observed. It changes the strap only around reset pulses, or deliberately after reset to show that the change is ignored. Each terminal state, halted or hung, is left only through a fresh reset before the next scenario.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
    typedef enum logic [1:0] {
        SRC_STEP   = 2'd0,
        SRC_OPCODE = 2'd1,
        SRC_DRHIT  = 2'd2
    } dtr_src_e;
    localparam int unsigned DTR_NSRC = 3;
endpackage

// File: rtl/dtr_bp_decode.sv
module dtr_bp_decode #(
    parameter int unsigned       BYTE_W    = 8,
    parameter logic [BYTE_W-1:0] BP_OPCODE = 8'hF1
) (
    input  logic              valid_i,
    input  logic              single_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              hit_o
);
    always_comb begin
        hit_o = valid_i && single_i && (byte_i == BP_OPCODE);
    end
endmodule

// File: rtl/dtr_prio.sv
module dtr_prio #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    always_comb begin
        grant_o = '0;
        any_o   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i] && !any_o) begin
                grant_o[i] = 1'b1;
                any_o      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dbg_trap_router.sv
module dbg_trap_router #(
    parameter int unsigned       BYTE_W    = 8,
    parameter int unsigned       VEC_W     = 8,
    parameter logic [BYTE_W-1:0] BP_OPCODE = 8'hF1,
    parameter logic [VEC_W-1:0]  DEBUG_VEC = 8'd1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mode_emu_i,
    input  logic              insn_valid_i,
    input  logic              insn_single_i,
    input  logic [BYTE_W-1:0] insn_byte_i,
    input  logic              step_trap_i,
    input  logic              drhit_i,
    input  logic              redir_wr_i,
    input  logic              redir_wdata_i,
    input  logic              emu_arm_i,
    input  logic              exc_ack_i,
    output logic              exc_valid_o,
    output logic [VEC_W-1:0]  exc_vector_o,
    output logic              tf_set_o,
    output logic              tf_keep_o,
    output logic              emu_break_o,
    output logic              emu_halt_o,
    output logic              hang_o
);
    import dtr_pkg::*;

    typedef struct packed {
        logic             redir;
        logic             mode;
        logic             pending;
        logic             exc_valid;
        logic [VEC_W-1:0] vec;
        logic             tf_set;
        logic             tf_keep;
        logic             emu_break;
        logic             halt;
        logic             hang;
    } state_t;

    state_t q, d;

    logic                bp_hit;
    logic [DTR_NSRC-1:0] req;
    logic [DTR_NSRC-1:0] grant;
    logic                any_req;
    logic                accept;

    dtr_bp_decode #(
        .BYTE_W    (BYTE_W),
        .BP_OPCODE (BP_OPCODE)
    ) u_decode (
        .valid_i  (insn_valid_i),
        .single_i (insn_single_i),
        .byte_i   (insn_byte_i),
        .hit_o    (bp_hit)
    );

    // Index order encodes priority: highest index wins.
    always_comb begin
        req             = '0;
        req[SRC_DRHIT]  = drhit_i;
        req[SRC_OPCODE] = bp_hit;
        req[SRC_STEP]   = step_trap_i;
    end

    dtr_prio #(
        .N (DTR_NSRC)
    ) u_prio (
        .req_i   (req),
        .grant_o (grant),
        .any_o   (any_req)
    );

    always_comb begin
        d           = q;
        d.exc_valid = 1'b0;
        d.emu_break = 1'b0;

        if (redir_wr_i) begin
            d.redir = redir_wdata_i;
        end else if (emu_arm_i) begin
            d.redir = 1'b1;
        end

        if (q.pending && exc_ack_i) begin
            d.pending = 1'b0;
            d.vec     = '0;
            d.tf_set  = 1'b0;
            d.tf_keep = 1'b0;
        end

        accept = any_req && !q.pending && !q.halt && !q.hang;

        if (accept) begin
            if (q.redir) begin
                if (q.mode) begin
                    d.emu_break = 1'b1;
                    d.halt      = 1'b1;
                end else begin
                    d.hang = 1'b1;
                end
            end else begin
                d.exc_valid = 1'b1;
                d.pending   = 1'b1;
                d.vec       = DEBUG_VEC;
                d.tf_set    = grant[SRC_STEP];
                d.tf_keep   = grant[SRC_OPCODE] | grant[SRC_DRHIT];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q      <= '0;
            q.mode <= mode_emu_i;
        end else begin
            q <= d;
        end
    end

    assign exc_valid_o  = q.exc_valid;
    assign exc_vector_o = q.vec;
    assign tf_set_o     = q.tf_set;
    assign tf_keep_o    = q.tf_keep;
    assign emu_break_o  = q.emu_break;
    assign emu_halt_o   = q.halt;
    assign hang_o       = q.hang;
endmodule

// File: rtl/dtr_checker.sv
module dtr_checker #(
    parameter int unsigned VEC_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             mode_q,
    input logic             exc_ack_i,
    input logic             exc_valid_o,
    input logic [VEC_W-1:0] exc_vector_o,
    input logic             tf_set_o,
    input logic             tf_keep_o,
    input logic             emu_break_o,
    input logic             emu_halt_o,
    input logic             hang_o
);
    a_r6_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_valid_o |=> !exc_valid_o);

    a_r6_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_vector_o != '0 && !exc_ack_i) |=>
            ($stable(exc_vector_o) && $stable(tf_set_o) && $stable(tf_keep_o)));

    a_r11_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_vector_o != '0 && exc_ack_i) |=>
            (exc_vector_o == '0 && !tf_set_o && !tf_keep_o));

    a_r3_flag_controls_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(tf_set_o && tf_keep_o));

    a_r8_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        emu_halt_o |=> emu_halt_o);

    a_r8_break_only_emulator: assert property (@(posedge clk_i) disable iff (!rst_ni)
        emu_break_o |-> (mode_q && !exc_valid_o && emu_halt_o));

    a_r9_hang_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hang_o |=> hang_o);

    a_r9_hang_only_production: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hang_o |-> (!mode_q && !emu_break_o));
endmodule

bind dbg_trap_router dtr_checker #(
    .VEC_W (VEC_W)
) u_dtr_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_q       (q.mode),
    .exc_ack_i    (exc_ack_i),
    .exc_valid_o  (exc_valid_o),
    .exc_vector_o (exc_vector_o),
    .tf_set_o     (tf_set_o),
    .tf_keep_o    (tf_keep_o),
    .emu_break_o  (emu_break_o),
    .emu_halt_o   (emu_halt_o),
    .hang_o       (hang_o)
);

// File: tb/tb_dbg_trap_router.sv
`timescale 1ns/1ps
module tb_dbg_trap_router;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       mode_emu_i = 1'b0;
    logic       insn_valid_i = 1'b0;
    logic       insn_single_i = 1'b0;
    logic [7:0] insn_byte_i = 8'h00;
    logic       step_trap_i = 1'b0;
    logic       drhit_i = 1'b0;
    logic       redir_wr_i = 1'b0;
    logic       redir_wdata_i = 1'b0;
    logic       emu_arm_i = 1'b0;
    logic       exc_ack_i = 1'b0;
    logic       exc_valid_o;
    logic [7:0] exc_vector_o;
    logic       tf_set_o;
    logic       tf_keep_o;
    logic       emu_break_o;
    logic       emu_halt_o;
    logic       hang_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk_i = ~clk_i;

    dbg_trap_router dut (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .mode_emu_i    (mode_emu_i),
        .insn_valid_i  (insn_valid_i),
        .insn_single_i (insn_single_i),
        .insn_byte_i   (insn_byte_i),
        .step_trap_i   (step_trap_i),
        .drhit_i       (drhit_i),
        .redir_wr_i    (redir_wr_i),
        .redir_wdata_i (redir_wdata_i),
        .emu_arm_i     (emu_arm_i),
        .exc_ack_i     (exc_ack_i),
        .exc_valid_o   (exc_valid_o),
        .exc_vector_o  (exc_vector_o),
        .tf_set_o      (tf_set_o),
        .tf_keep_o     (tf_keep_o),
        .emu_break_o   (emu_break_o),
        .emu_halt_o    (emu_halt_o),
        .hang_o        (hang_o)
    );

    // {drhit, step, ivalid, isingle, byte[7:0], exp_valid, exp_tfset, exp_tfkeep, 0}
    localparam logic [15:0] TBL [9] = '{
        16'h3F1A, // R2 breakpoint byte, single
        16'h2F10, // R2 breakpoint byte but multi-byte
        16'h3CC0, // R2 other byte
        16'h1F10, // R2 valid low
        16'h400C, // R3 single-step
        16'h800A, // R4 debug-register hit
        16'hFF1A, // R5 all three: hit wins
        16'h7F1A, // R5 opcode over step
        16'h790C  // R5 step with non-breakpoint byte
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        insn_valid_i = 1'b0; insn_single_i = 1'b0; insn_byte_i = 8'h00;
        step_trap_i = 1'b0; drhit_i = 1'b0; redir_wr_i = 1'b0;
        redir_wdata_i = 1'b0; emu_arm_i = 1'b0; exc_ack_i = 1'b0;
    endtask

    // Inputs already set at a falling edge; one rising edge, then back to falling.
    task automatic step_clk();
        @(posedge clk_i);
        @(negedge clk_i);
        clear_in();
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk_i);
        clear_in();
        rst_ni = 1'b0;
        mode_emu_i = mode;
        repeat (2) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
    endtask

    task automatic ev(input logic dr, input logic st, input logic iv,
                      input logic is, input logic [7:0] b);
        drhit_i = dr; step_trap_i = st; insn_valid_i = iv;
        insn_single_i = is; insn_byte_i = b;
        step_clk();
    endtask

    task automatic ack();
        exc_ack_i = 1'b1;
        step_clk();
    endtask

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);
        // R1 reset state
        chk("R1", "exc_valid", exc_valid_o, 0);
        chk("R1", "vector", exc_vector_o, 0);
        chk("R1", "tf_set|tf_keep", {tf_set_o, tf_keep_o}, 0);
        chk("R1", "break|halt|hang", {emu_break_o, emu_halt_o, hang_o}, 0);

        // Table walk: redirection off
        for (int i = 0; i < 9; i++) begin
            ev(TBL[i][15], TBL[i][14], TBL[i][13], TBL[i][12], TBL[i][11:4]);
            chk("R2/R3/R4/R5", $sformatf("row%0d valid", i), exc_valid_o, TBL[i][3]);
            chk("R2/R3/R4/R5", $sformatf("row%0d vector", i), exc_vector_o, TBL[i][3] ? 1 : 0);
            chk("R2/R3/R4/R5", $sformatf("row%0d tf_set", i), tf_set_o, TBL[i][2]);
            chk("R2/R3/R4/R5", $sformatf("row%0d tf_keep", i), tf_keep_o, TBL[i][1]);
            if (TBL[i][3]) ack();
        end

        // R6 hold and drop while outstanding
        ev(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        chk("R6", "valid first cycle", exc_valid_o, 1);
        step_clk();
        chk("R6", "valid one cycle only", exc_valid_o, 0);
        chk("R6", "vector held", exc_vector_o, 1);
        chk("R6", "tf_set held", tf_set_o, 1);
        ev(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R6", "event dropped valid", exc_valid_o, 0);
        chk("R6", "event dropped tf_keep", tf_keep_o, 0);
        chk("R6", "event dropped tf_set", tf_set_o, 1);
        ack();
        // R11 acknowledge clears, next event accepted
        chk("R11", "vector cleared", exc_vector_o, 0);
        chk("R11", "flags cleared", {tf_set_o, tf_keep_o}, 0);
        ev(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R11", "accepted after ack", exc_valid_o, 1);
        ack();

        // R7 write wins over arm
        redir_wr_i = 1'b1; redir_wdata_i = 1'b0; emu_arm_i = 1'b1;
        step_clk();
        ev(1'b0, 1'b0, 1'b1, 1'b1, 8'hF1);
        chk("R7", "write over arm keeps redir off", exc_valid_o, 1);
        chk("R7", "no hang", hang_o, 0);
        ack();
        // R7 write in same cycle as event uses old value
        redir_wr_i = 1'b1; redir_wdata_i = 1'b1;
        drhit_i = 1'b1;
        step_clk();
        chk("R7", "same-cycle write uses old value", exc_valid_o, 1);
        ack();
        // R7 direct clear
        redir_wr_i = 1'b1; redir_wdata_i = 1'b0;
        step_clk();
        ev(0, 1, 0, 0, 8'h00);
        chk("R7", "cleared by write", exc_valid_o, 1);
        ack();

        // R10 strap change after reset ignored; R9 production hang
        mode_emu_i = 1'b1;
        emu_arm_i = 1'b1;
        step_clk();
        ev(1'b0, 1'b0, 1'b1, 1'b1, 8'hF1);
        chk("R10", "strap change ignored, no break", emu_break_o, 0);
        chk("R9", "hang raised", hang_o, 1);
        chk("R9", "no exception", exc_valid_o, 0);
        step_clk();
        step_clk();
        chk("R9", "hang sticky", hang_o, 1);
        ev(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R9", "later event ignored", {exc_valid_o, emu_break_o}, 0);
        do_reset(1'b1);
        chk("R1", "hang cleared by reset", hang_o, 0);

        // R8 emulator-capable part
        mode_emu_i = 1'b0;
        redir_wr_i = 1'b1; redir_wdata_i = 1'b1;
        step_clk();
        ev(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        chk("R8", "break strobe", emu_break_o, 1);
        chk("R8", "halt", emu_halt_o, 1);
        chk("R8", "no exception", exc_valid_o, 0);
        chk("R8", "no hang", hang_o, 0);
        step_clk();
        chk("R8", "strobe one cycle", emu_break_o, 0);
        chk("R8", "halt sticky", emu_halt_o, 1);
        ev(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R8", "later event ignored", {exc_valid_o, emu_break_o}, 0);
        do_reset(1'b0);
        chk("R1", "halt cleared by reset", emu_halt_o, 0);
        ev(1'b0, 1'b0, 1'b1, 1'b1, 8'hF1);
        chk("R1", "redir off after reset", exc_valid_o, 1);
        ack();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule